// File: doc/BRIEF.md
# Compare-Match Timer with Waveform Pin

An 8-bit up-counter that advances once for each cycle in which a timer-clock enable is high. A compare register is checked against the count on every advancing cycle. What happens on a match depends on a 2-bit mode field. In free-running mode the counter keeps going and wraps from 0xFF to 0x00. In clear-on-match mode the counter returns to zero, so the compare value sets the period. A sticky overflow flag records each wrap from the all-ones value to zero. Software clears the flag with a dedicated input.

A single waveform pin is driven by a 2-bit action field. On a compare match the pin can stay as it is, toggle, go low or go high. Writing a new action never moves the pin by itself. The new action is used at the next compare match, or at once when the force strobe is pulsed. A force moves only the pin. It leaves the count and the flag alone.

The block is built from three small state machines:
- **Counter step selector.** States `STEP_HOLD`, `STEP_LOAD`, `STEP_INC` and `STEP_CLR`. Each cycle picks one: hold with no enable, load on a software write, increment on enable, or clear on a match in clear-on-match mode.
- **Overflow flag.** States `FLAG_IDLE` and `FLAG_SET`. It moves idle→set on a wrap and set→idle on a clear with no wrap in the same cycle.
- **Pin.** States `PIN_LOW` and `PIN_HIGH`. On an action event it goes low→high or high→low according to the action field.

Top module: `tc_cmp_timer`

## Requirements
- R1: A synchronous reset sets count, compare value, mode field, action field, waveform pin and overflow flag to zero.
- R2: The count changes only in cycles where `tick` or `cnt_we` is high; otherwise it holds.
- R3: In mode 0, and in the reserved modes 1 and 3, a tick increments the count, and a tick at 0xFF wraps it to 0x00.
- R4: The flag is set at the edge where a tick moves the count from 0xFF to 0x00, in either mode. It stays set until `flag_clr` is high. When a set and `flag_clr` fall in the same cycle, the flag ends set.
- R5: In mode 2, a tick while the count equals the compare value makes the count 0 at the next edge.
- R6: A counter write in a tick cycle loads the written value. That cycle makes no increment, no compare match and no flag set.
- R7: A compare match (tick, no counter write, count equal to compare value) applies the action field to the pin: 00 leaves it, 01 toggles it, 10 drives 0, 11 drives 1. The action field never alters the count sequence.
- R8: A write to the action field does not change the pin. A match in the same cycle as the write uses the previous action.
- R9: A force pulse applies the current action to the pin at the next edge. It does not change the count or the flag.
- R10: A force and a compare match in the same cycle apply the action once (a single toggle, not two).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer-clock enable |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | Compare value |
| mode_we | input | 1 | Mode field write strobe |
| mode_wdata | input | 2 | Mode: 2 clear-on-match, others free-running |
| act_we | input | 1 | Action field write strobe |
| act_wdata | input | 2 | Pin action at match/force |
| force_cmp | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | Overflow flag clear |
| count | output | 8 | Current count |
| cmp_val | output | 8 | Current compare value |
| ovf_flag | output | 1 | Sticky overflow flag |
| wave | output | 1 | Waveform pin |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a force and a compare match. The bench drives the force strobe in the exact tick cycle where the count equals the compare value, with the toggle action selected. It expects one inversion of the pin, and it expects the counter cleared as in a normal match.

The second pair is a flag set and a flag clear. The bench loads 0xFF and raises tick together with `flag_clr`. It expects the flag to read set afterwards. It also places an action-field write and a counter write on match cycles, and checks that the old action is used and that the match is suppressed.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_CTC  = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_LOAD,
        STEP_INC,
        STEP_CLR
    } step_e;

    typedef enum logic {
        FLAG_IDLE,
        FLAG_SET
    } flag_e;

    typedef enum logic {
        PIN_LOW,
        PIN_HIGH
    } pin_e;

    localparam logic [1:0] MODE_CODE_CTC = 2'd2;

    function automatic mode_e decode_mode(input logic [1:0] code);
        return (code == MODE_CODE_CTC) ? MODE_CTC : MODE_FREE;
    endfunction

endpackage

// File: rtl/tcm_counter.sv
module tcm_counter
    import tcm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cmp,
    input  mode_e        mode,
    output logic [W-1:0] count,
    output logic         match_ev,
    output logic         wrap_ev
);
    localparam logic [W-1:0] TOP_ALL = {W{1'b1}};

    step_e step;
    logic  tick_eff;

    assign tick_eff = tick & ~wr_en;
    assign match_ev = tick_eff & (count == cmp);
    assign wrap_ev  = tick_eff & (count == TOP_ALL);

    always_comb begin
        if (wr_en)
            step = STEP_LOAD;
        else if (!tick)
            step = STEP_HOLD;
        else if (mode == MODE_CTC && count == cmp)
            step = STEP_CLR;
        else
            step = STEP_INC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case (step)
                STEP_HOLD: count <= count;
                STEP_LOAD: count <= wr_data;
                STEP_INC:  count <= count + 1'b1;
                STEP_CLR:  count <= '0;
                default:   count <= count;
            endcase
        end
    end

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(count));
    p_wrap_free_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && mode == MODE_FREE && count == TOP_ALL) |=> (count == '0));
    p_ctc_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && mode == MODE_CTC && count == cmp) |=> (count == '0));
    p_write_wins_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (count == $past(wr_data)));
endmodule

// File: rtl/tcm_flag.sv
module tcm_flag
    import tcm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr,
    output logic flag
);
    flag_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            FLAG_IDLE: if (set_ev) state_nx = FLAG_SET;
            FLAG_SET:  if (clr && !set_ev) state_nx = FLAG_IDLE;
            default:   state_nx = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= FLAG_IDLE;
        else     state <= state_nx;
    end

    always_comb flag = (state == FLAG_SET);

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> flag);
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_ev) |=> !flag);
endmodule

// File: rtl/tcm_wave.sv
module tcm_wave
    import tcm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic match_ev,
    input  logic force_ev,
    input  act_e act,
    output logic pin
);
    pin_e state, state_nx;
    logic fire;

    assign fire = match_ev | force_ev;

    always_comb begin
        state_nx = state;
        if (fire) begin
            unique case (state)
                PIN_LOW:  if (act == ACT_TOGGLE || act == ACT_SET)   state_nx = PIN_HIGH;
                PIN_HIGH: if (act == ACT_TOGGLE || act == ACT_CLEAR) state_nx = PIN_LOW;
                default:  state_nx = PIN_LOW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PIN_LOW;
        else     state <= state_nx;
    end

    always_comb pin = (state == PIN_HIGH);

    p_pin_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!match_ev && !force_ev) |=> $stable(pin));
    p_single_toggle_r10: assert property (@(posedge clk) disable iff (rst)
        ((match_ev || force_ev) && act == ACT_TOGGLE) |=> (pin != $past(pin)));
    p_set_action_r7: assert property (@(posedge clk) disable iff (rst)
        ((match_ev || force_ev) && act == ACT_SET) |=> pin);
    p_clear_action_r7: assert property (@(posedge clk) disable iff (rst)
        ((match_ev || force_ev) && act == ACT_CLEAR) |=> !pin);
endmodule

// File: rtl/tc_cmp_timer.sv
module tc_cmp_timer
    import tcm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         mode_we,
    input  logic [1:0]   mode_wdata,
    input  logic         act_we,
    input  logic [1:0]   act_wdata,
    input  logic         force_cmp,
    input  logic         flag_clr,
    output logic [W-1:0] count,
    output logic [W-1:0] cmp_val,
    output logic         ovf_flag,
    output logic         wave
);
    logic [1:0] mode_code;
    act_e       act_q;
    mode_e      mode;
    logic       match_ev;
    logic       wrap_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_val   <= '0;
            mode_code <= '0;
            act_q     <= ACT_NONE;
        end else begin
            if (cmp_we)  cmp_val   <= cmp_wdata;
            if (mode_we) mode_code <= mode_wdata;
            if (act_we)  act_q     <= act_e'(act_wdata);
        end
    end

    assign mode = decode_mode(mode_code);

    tcm_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wr_en    (cnt_we),
        .wr_data  (cnt_wdata),
        .cmp      (cmp_val),
        .mode     (mode),
        .count    (count),
        .match_ev (match_ev),
        .wrap_ev  (wrap_ev)
    );

    tcm_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_ev (wrap_ev),
        .clr    (flag_clr),
        .flag   (ovf_flag)
    );

    tcm_wave u_wave (
        .clk      (clk),
        .rst      (rst),
        .match_ev (match_ev),
        .force_ev (force_cmp),
        .act      (act_q),
        .pin      (wave)
    );

    p_force_keeps_count_r9: assert property (@(posedge clk) disable iff (rst)
        (force_cmp && !tick && !cnt_we) |=> $stable(count));
    p_write_no_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt_we && !ovf_flag) |=> !ovf_flag);
endmodule

// File: tb/tc_cmp_timer_bench.sv
module tc_cmp_timer_bench;
    logic       clk = 1'b0;
    logic       rst, tick, cnt_we, cmp_we, mode_we, act_we, force_cmp, flag_clr;
    logic [7:0] cnt_wdata, cmp_wdata;
    logic [1:0] mode_wdata, act_wdata;
    logic [7:0] count, cmp_val;
    logic       ovf_flag, wave;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_cnt = 8'h00, m_cmp = 8'h00;
    logic [1:0] m_mode = 2'd0, m_act = 2'd0;
    logic       m_pin = 1'b0, m_flag = 1'b0;

    logic [7:0] q_cnt[$];
    logic [7:0] q_cmp[$];
    logic       q_flag[$];
    logic       q_pin[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    tc_cmp_timer u_tc_cmp_timer (
        .clk(clk), .rst(rst), .tick(tick),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .act_we(act_we), .act_wdata(act_wdata),
        .force_cmp(force_cmp), .flag_clr(flag_clr),
        .count(count), .cmp_val(cmp_val), .ovf_flag(ovf_flag), .wave(wave)
    );

    task automatic idle_inputs();
        rst = 0; tick = 0; cnt_we = 0; cmp_we = 0; mode_we = 0; act_we = 0;
        force_cmp = 0; flag_clr = 0;
        cnt_wdata = '0; cmp_wdata = '0; mode_wdata = '0; act_wdata = '0;
    endtask

    // Reference model built from the requirements; pushes the expected post-edge state.
    task automatic step(input string tag);
        logic       teff, match, fire;
        logic [7:0] n_cnt;
        if (rst) begin
            m_cnt = 0; m_cmp = 0; m_mode = 0; m_act = 0; m_pin = 0; m_flag = 0;
        end else begin
            teff  = tick && !cnt_we;
            match = teff && (m_cnt == m_cmp);
            fire  = match || force_cmp;
            if (cnt_we)                          n_cnt = cnt_wdata;
            else if (!tick)                      n_cnt = m_cnt;
            else if (m_mode == 2'd2 && match)    n_cnt = 8'h00;
            else                                 n_cnt = m_cnt + 8'd1;
            if (teff && m_cnt == 8'hFF)          m_flag = 1'b1;
            else if (flag_clr)                   m_flag = 1'b0;
            if (fire) begin
                case (m_act)
                    2'b01:   m_pin = ~m_pin;
                    2'b10:   m_pin = 1'b0;
                    2'b11:   m_pin = 1'b1;
                    default: m_pin = m_pin;
                endcase
            end
            m_cnt = n_cnt;
            if (cmp_we)  m_cmp  = cmp_wdata;
            if (mode_we) m_mode = mode_wdata;
            if (act_we)  m_act  = act_wdata;
        end
        q_cnt.push_back(m_cnt); q_cmp.push_back(m_cmp);
        q_flag.push_back(m_flag); q_pin.push_back(m_pin); q_tag.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    // Monitor: pop one expectation per edge and compare.
    always @(posedge clk) begin
        #2;
        if (q_cnt.size() > 0) begin
            logic [7:0] e_cnt, e_cmp;
            logic       e_flag, e_pin;
            string      t;
            e_cnt = q_cnt.pop_front(); e_cmp = q_cmp.pop_front();
            e_flag = q_flag.pop_front(); e_pin = q_pin.pop_front(); t = q_tag.pop_front();
            checks++;
            if (count !== e_cnt || cmp_val !== e_cmp || ovf_flag !== e_flag || wave !== e_pin) begin
                failures++;
                $display("FAIL %s: got cnt=%h cmp=%h flag=%b pin=%b, expected cnt=%h cmp=%h flag=%b pin=%b",
                         t, count, cmp_val, ovf_flag, wave, e_cnt, e_cmp, e_flag, e_pin);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got running, expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        @(negedge clk);
        // R1 reset, with stray strobes that must be ignored
        rst = 1; tick = 1; act_we = 1; act_wdata = 2'b11; step("R1");
        rst = 1; step("R1");

        // R2 gating: ticks on alternate cycles
        for (int i = 0; i < 6; i++) begin
            tick = (i % 2 == 0); step("R2");
        end

        // R3/R4 free-running wrap and sticky flag
        cnt_we = 1; cnt_wdata = 8'hFD; step("R6");
        for (int i = 0; i < 5; i++) begin tick = 1; step("R3"); end
        step("R4");
        flag_clr = 1; step("R4");
        // set and clear in the same cycle: set wins
        cnt_we = 1; cnt_wdata = 8'hFF; step("R6");
        tick = 1; flag_clr = 1; step("R4");
        flag_clr = 1; step("R4");

        // R3 reserved mode 3 behaves as free-running
        mode_we = 1; mode_wdata = 2'd3; cmp_we = 1; cmp_wdata = 8'h02; step("R3");
        cnt_we = 1; cnt_wdata = 8'hFE; step("R3");
        for (int i = 0; i < 4; i++) begin tick = 1; step("R3"); end

        // R5/R7 clear-on-match with toggle action
        mode_we = 1; mode_wdata = 2'd2; cmp_we = 1; cmp_wdata = 8'h04;
        act_we = 1; act_wdata = 2'b01; cnt_we = 1; cnt_wdata = 8'h00; step("R5");
        for (int i = 0; i < 12; i++) begin tick = 1; step("R7"); end

        // R8: action write changes nothing until a match; match in write cycle uses old action
        act_we = 1; act_wdata = 2'b11; step("R8");
        step("R8");
        act_we = 1; act_wdata = 2'b10; step("R8");
        while (m_cnt != m_cmp) begin tick = 1; step("R8"); end
        tick = 1; act_we = 1; act_wdata = 2'b01; step("R8");
        while (m_cnt != m_cmp) begin tick = 1; step("R7"); end
        tick = 1; step("R7");

        // R9 force: pin only
        act_we = 1; act_wdata = 2'b11; step("R9");
        cnt_we = 1; cnt_wdata = 8'h01; step("R9");
        force_cmp = 1; step("R9");
        force_cmp = 1; tick = 1; step("R9");
        act_we = 1; act_wdata = 2'b10; step("R9");
        force_cmp = 1; step("R9");

        // R10 force coincident with a match under toggle
        act_we = 1; act_wdata = 2'b01; step("R10");
        while (m_cnt != m_cmp) begin tick = 1; step("R10"); end
        tick = 1; force_cmp = 1; step("R10");
        step("R10");

        // R6 counter write in a matching tick cycle suppresses the match
        while (m_cnt != m_cmp) begin tick = 1; step("R6"); end
        tick = 1; cnt_we = 1; cnt_wdata = 8'h02; step("R6");
        tick = 1; step("R6");
        // R6 write over 0xFF tick: no flag set
        flag_clr = 1; step("R6");
        mode_we = 1; mode_wdata = 2'd0; cnt_we = 1; cnt_wdata = 8'hFF; step("R6");
        tick = 1; cnt_we = 1; cnt_wdata = 8'h10; step("R6");
        step("R6");

        // R7 action 00 leaves the pin at a match
        act_we = 1; act_wdata = 2'b00; cmp_we = 1; cmp_wdata = 8'h11; step("R7");
        tick = 1; step("R7");
        tick = 1; step("R7");

        @(posedge clk); #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule